// File: doc/BRIEF.md
# Audio switch matrix controller

This block keeps the routing state of a crosspoint audio switch. The switch can send any of four external stereo input pairs, the return path from an external effects processor, or silence to each of two stereo output pairs. The block drives one select field per output pair. A simple strobe port carries the configuration writes. Each write gives a subaddress, a register address and a data word. The port stands in for a serial control bus.

The routing state sits in the always-powered part of the device. It is cleared only by the power-on reset input `por_n`. The main reset `rst_n` does not touch the routing. It only marks the built-in default routing as pending. The default is applied on the first later write to the routing subaddress, unless that write targets the routing register itself; in that case the written value is used and the default is dropped. While `standby` is high, the control side is treated as unpowered. The switches keep their positions and keep passing audio.

Top module: `route_matrix_ctrl`

## Requirements
- R1: While `por_n` is low, both select fields of `out_sel` read 5 (mute), and the default routing is marked pending.
- R2: Select codes are 0 to 3 for external input pairs 0 to 3, 4 for the processor return, and 5 for mute. Output pair k uses bits [3k+2:3k] of both `wr_data` and `out_sel`. The fields are independent, so any source can feed either output.
- R3: A write to subaddress 0x12, register 0x3E is the routing register. It changes `out_sel` on the clock edge that captures it, to the written fields.
- R4: A written select code of 6 or 7 shows as 5 (mute) on its output field.
- R5: A low pulse on `rst_n` leaves `out_sel` unchanged and marks the default routing pending.
- R6: While the default is pending, the first write to subaddress 0x12 at a register other than 0x3E sets `out_sel` to the default: output 0 gets code 0 and output 1 gets code 4 (value 0x20). This clears the pending mark.
- R7: While the default is pending, a first write to the routing register applies the written value. The default is then not applied by any later write.
- R8: When no default is pending, writes to subaddress 0x12 at registers other than 0x3E leave `out_sel` unchanged.
- R9: Writes to any subaddress other than 0x12 never change `out_sel` and do not clear the pending mark.
- R10: While `standby` is high, all writes are ignored and `out_sel` holds.
- R11: Writes presented while `rst_n` is low are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Control clock |
| por_n | input | 1 | Power-on reset of the always-on domain, active low, asynchronous |
| rst_n | input | 1 | Main reset, active low, asynchronous; routing kept |
| standby | input | 1 | High while the control supply is off |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_sub | input | 8 | Write subaddress |
| wr_addr | input | 8 | Register address within the subaddress |
| wr_data | input | 16 | Write data; the low 6 bits hold the select fields |
| out_sel | output | 6 | Select fields for output pairs 1 and 0 |

## Verification
A pending mark left set by mistake shows up one edge after the next write to subaddress 0x12: the outputs jump to 0x20 when they should hold. A pending mark that was cleared too early shows up the same way, because the outputs fail to take the default. A routing register reset by `rst_n` shows up as mute at the port as soon as the reset is asserted. The scoreboard compares `out_sel` every cycle after each operation, so a stray update during standby or reset is caught within one cycle.

// File: rtl/route_pkg.sv
package route_pkg;
   // decoded write request, already qualified by standby and main reset
   typedef struct packed {
      logic sub_hit;
      logic reg_hit;
   } wr_dec_t;

   function automatic int sel_width(input int n_in);
      return $clog2(n_in + 2);
   endfunction
endpackage

// File: rtl/route_wr_decode.sv
module route_wr_decode
   import route_pkg::*;
#(
   parameter int SUB_W = 8,
   parameter int REG_W = 8,
   parameter logic [SUB_W-1:0] ROUTE_SUB = 8'h12,
   parameter logic [REG_W-1:0] ROUTE_REG = 8'h3E
) (
   input  logic             wr_en,
   input  logic             standby,
   input  logic             rst_n,
   input  logic [SUB_W-1:0] wr_sub,
   input  logic [REG_W-1:0] wr_addr,
   output wr_dec_t          dec
);
   logic accept;

   always_comb begin
      accept      = wr_en & ~standby & rst_n;
      dec.sub_hit = accept & (wr_sub == ROUTE_SUB);
      dec.reg_hit = dec.sub_hit & (wr_addr == ROUTE_REG);
   end
endmodule

// File: rtl/route_pending.sv
module route_pending (
   input  logic clk,
   input  logic rst_any_n,
   input  logic sub_hit,
   output logic pending
);
   always_ff @(posedge clk or negedge rst_any_n) begin
      if (!rst_any_n)   pending <= 1'b1;
      else if (sub_hit) pending <= 1'b0;
   end
endmodule

// File: rtl/route_field.sv
module route_field #(
   parameter int NUM_IN = 4,
   parameter int SEL_W = 3,
   parameter bit CLAMP_INVALID = 1'b1,
   parameter logic [SEL_W-1:0] DEF_SEL = '0
) (
   input  logic             clk,
   input  logic             por_n,
   input  logic             load,
   input  logic             use_data,
   input  logic [SEL_W-1:0] data_field,
   output logic [SEL_W-1:0] sel
);
   localparam logic [SEL_W-1:0] MUTE_C = SEL_W'(NUM_IN + 1);

   logic             code_ok;
   logic             take;
   logic [SEL_W-1:0] wr_val;

   assign code_ok = (data_field <= MUTE_C);

   generate
      if (CLAMP_INVALID) begin : g_clamp
         assign wr_val = code_ok ? data_field : MUTE_C;
         assign take   = 1'b1;
      end else begin : g_reject
         assign wr_val = data_field;
         assign take   = code_ok;
      end
   endgenerate

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         sel <= MUTE_C;
      end else if (load) begin
         if (!use_data)  sel <= DEF_SEL;
         else if (take)  sel <= wr_val;
      end
   end
endmodule

// File: rtl/route_matrix_ctrl.sv
module route_matrix_ctrl
   import route_pkg::*;
#(
   parameter int NUM_IN = 4,
   parameter int NUM_OUT = 2,
   parameter int SUB_W = 8,
   parameter int REG_W = 8,
   parameter int DATA_W = 16,
   parameter logic [SUB_W-1:0] ROUTE_SUB = 8'h12,
   parameter logic [REG_W-1:0] ROUTE_REG = 8'h3E,
   parameter logic [DATA_W-1:0] DEF_ROUTE = 16'h0020,
   parameter bit CLAMP_INVALID = 1'b1,
   localparam int SEL_W = sel_width(NUM_IN),
   localparam int OUT_W = NUM_OUT * SEL_W
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              rst_n,
   input  logic              standby,
   input  logic              wr_en,
   input  logic [SUB_W-1:0]  wr_sub,
   input  logic [REG_W-1:0]  wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic [OUT_W-1:0]  out_sel
);
   // elaboration-time parameter checks
   generate
      if (NUM_IN < 1)      begin : g_bad_in   $error("NUM_IN must be at least 1"); end
      if (NUM_OUT < 1)     begin : g_bad_out  $error("NUM_OUT must be at least 1"); end
      if (OUT_W > DATA_W)  begin : g_bad_data $error("DATA_W too narrow for all select fields"); end
      for (genvar d = 0; d < NUM_OUT; d++) begin : g_def_chk
         if (int'(DEF_ROUTE[d*SEL_W +: SEL_W]) > NUM_IN + 1) begin : g_bad_def
            $error("DEF_ROUTE holds an undefined select code");
         end
      end
      if (DATA_W > OUT_W) begin : g_spare
         logic unused_hi;
         assign unused_hi = ^wr_data[DATA_W-1:OUT_W];
      end
   endgenerate

   wr_dec_t dec;
   logic    pending;
   logic    rst_any_n;
   logic    load;

   assign rst_any_n = por_n & rst_n;

   route_wr_decode #(
      .SUB_W(SUB_W), .REG_W(REG_W), .ROUTE_SUB(ROUTE_SUB), .ROUTE_REG(ROUTE_REG)
   ) u_dec (
      .wr_en(wr_en), .standby(standby), .rst_n(rst_n),
      .wr_sub(wr_sub), .wr_addr(wr_addr), .dec(dec)
   );

   route_pending u_pend (
      .clk(clk), .rst_any_n(rst_any_n), .sub_hit(dec.sub_hit), .pending(pending)
   );

   // routing register write always loads; other subaddress hits load the default once
   assign load = dec.reg_hit | (dec.sub_hit & pending);

   generate
      for (genvar k = 0; k < NUM_OUT; k++) begin : g_out
         route_field #(
            .NUM_IN(NUM_IN), .SEL_W(SEL_W), .CLAMP_INVALID(CLAMP_INVALID),
            .DEF_SEL(DEF_ROUTE[k*SEL_W +: SEL_W])
         ) u_field (
            .clk(clk), .por_n(por_n), .load(load), .use_data(dec.reg_hit),
            .data_field(wr_data[k*SEL_W +: SEL_W]),
            .sel(out_sel[k*SEL_W +: SEL_W])
         );
      end
   endgenerate
endmodule

// File: rtl/route_matrix_ctrl_chk.sv
module route_matrix_ctrl_chk #(
   parameter int NUM_IN = 4,
   parameter int NUM_OUT = 2,
   parameter int SUB_W = 8,
   parameter int REG_W = 8,
   parameter int OUT_W = 6,
   parameter int SEL_W = 3,
   parameter logic [SUB_W-1:0] ROUTE_SUB = 8'h12,
   parameter logic [REG_W-1:0] ROUTE_REG = 8'h3E,
   parameter logic [OUT_W-1:0] DEF_OUT = 6'h20
) (
   input logic             clk,
   input logic             por_n,
   input logic             rst_n,
   input logic             standby,
   input logic             wr_en,
   input logic [SUB_W-1:0] wr_sub,
   input logic [REG_W-1:0] wr_addr,
   input logic [OUT_W-1:0] wr_low,
   input logic [OUT_W-1:0] out_sel,
   input logic             pending
);
   localparam logic [SEL_W-1:0] MUTE_C = SEL_W'(NUM_IN + 1);

   logic live_wr;
   logic sub_wr;
   assign live_wr = wr_en & ~standby & rst_n;
   assign sub_wr  = live_wr & (wr_sub == ROUTE_SUB);

   // R9
   other_sub_stable_chk: assert property (@(posedge clk) disable iff (!por_n)
      (wr_en && wr_sub != ROUTE_SUB) |=> $stable(out_sel));

   // R10
   standby_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
      standby |=> $stable(out_sel));

   // R5
   main_reset_keep_chk: assert property (@(posedge clk) disable iff (!por_n)
      !rst_n |=> $stable(out_sel));

   // R6
   default_apply_chk: assert property (@(posedge clk) disable iff (!por_n)
      (pending && sub_wr && wr_addr != ROUTE_REG) |=> (out_sel == DEF_OUT));

   // R8
   settled_other_reg_chk: assert property (@(posedge clk) disable iff (!por_n)
      (!pending && sub_wr && wr_addr != ROUTE_REG) |=> $stable(out_sel));

   generate
      for (genvar k = 0; k < NUM_OUT; k++) begin : g_fld
         // R4
         legal_code_chk: assert property (@(posedge clk) disable iff (!por_n)
            out_sel[k*SEL_W +: SEL_W] <= MUTE_C);
         // R3
         route_write_chk: assert property (@(posedge clk) disable iff (!por_n)
            (sub_wr && wr_addr == ROUTE_REG && wr_low[k*SEL_W +: SEL_W] <= MUTE_C)
            |=> (out_sel[k*SEL_W +: SEL_W] == $past(wr_low[k*SEL_W +: SEL_W])));
      end
   endgenerate
endmodule

bind route_matrix_ctrl route_matrix_ctrl_chk #(
   .NUM_IN(NUM_IN), .NUM_OUT(NUM_OUT), .SUB_W(SUB_W), .REG_W(REG_W),
   .OUT_W(OUT_W), .SEL_W(SEL_W), .ROUTE_SUB(ROUTE_SUB), .ROUTE_REG(ROUTE_REG),
   .DEF_OUT(DEF_ROUTE[OUT_W-1:0])
) u_chk (
   .clk(clk), .por_n(por_n), .rst_n(rst_n), .standby(standby), .wr_en(wr_en),
   .wr_sub(wr_sub), .wr_addr(wr_addr), .wr_low(wr_data[OUT_W-1:0]),
   .out_sel(out_sel), .pending(pending)
);

// File: tb/route_matrix_ctrl_test.sv
module route_matrix_ctrl_test;
   logic        clk = 1'b0;
   logic        por_n = 1'b0;
   logic        rst_n = 1'b0;
   logic        standby = 1'b0;
   logic        wr_en = 1'b0;
   logic [7:0]  wr_sub = '0;
   logic [7:0]  wr_addr = '0;
   logic [15:0] wr_data = '0;
   logic [5:0]  out_sel;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic [5:0] exp_q[$];
   string      tag_q[$];

   logic [5:0] m_route = 6'o55;
   bit         m_pend = 1'b1;

   localparam logic [5:0] DEF = 6'o40;

   always #10 clk = ~clk;

   route_matrix_ctrl uut (
      .clk(clk), .por_n(por_n), .rst_n(rst_n), .standby(standby), .wr_en(wr_en),
      .wr_sub(wr_sub), .wr_addr(wr_addr), .wr_data(wr_data), .out_sel(out_sel)
   );

   function automatic logic [5:0] fix(input logic [5:0] v);
      logic [2:0] a = v[2:0];
      logic [2:0] b = v[5:3];
      if (a > 3'd5) a = 3'd5;
      if (b > 3'd5) b = 3'd5;
      return {b, a};
   endfunction

   task automatic push(input string tag);
      exp_q.push_back(m_route);
      tag_q.push_back(tag);
   endtask

   task automatic write(input logic [7:0] s, input logic [7:0] a, input logic [15:0] d,
                        input string tag);
      @(negedge clk);
      wr_en = 1'b1; wr_sub = s; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
      if (!standby && rst_n && s == 8'h12) begin
         if (a == 8'h3E) m_route = fix(d[5:0]);
         else if (m_pend) m_route = DEF;
         m_pend = 1'b0;
      end
      push(tag);
   endtask

   task automatic main_reset(input string tag);
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); rst_n = 1'b1;
      m_pend = 1'b1;
      push(tag);
   endtask

   task automatic idle(input int n, input string tag);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         push(tag);
      end
   endtask

   // monitor: compare one expected item per cycle, after the edge settles
   always @(posedge clk) begin
      #2;
      if (exp_q.size() > 0) begin
         logic [5:0] e;
         string t;
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         checks++;
         if (out_sel !== e) begin
            errors++;
            $display("FAIL %s: out_sel=%o expected %o", t, out_sel, e);
         end
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      push("R1 power-on mute");
      @(negedge clk);
      por_n = 1'b1; rst_n = 1'b1;
      push("R1 mute after release");
      write(8'h10, 8'h3E, 16'h000B, "R9 other subaddress ignored");
      write(8'h13, 8'h00, 16'h0001, "R9 pending kept");
      write(8'h12, 8'h01, 16'h0000, "R6 default applied");
      write(8'h12, 8'h3E, 16'h000B, "R3 route write");
      write(8'h12, 8'h05, 16'h003F, "R8 other reg after settle");
      main_reset("R5 routing kept over reset");
      idle(2, "R5 routing still kept");
      write(8'h20, 8'h3E, 16'h0012, "R9 other subaddress while pending");
      write(8'h12, 8'h02, 16'h0000, "R6 default after main reset");
      main_reset("R5 reset keeps default routing");
      write(8'h12, 8'h3E, 16'h0014, "R7 first write is route reg");
      write(8'h12, 8'h07, 16'h0000, "R7 default never applied");
      write(8'h12, 8'h3E, 16'h003E, "R4 codes 7 and 6 read as mute");
      write(8'h12, 8'h3E, 16'h0033, "R4 mixed invalid and valid");
      for (int s = 0; s < 6; s++) begin
         write(8'h12, 8'h3E, 16'({3'(5 - s), 3'(s)}), "R2 full matrix");
      end
      @(negedge clk); standby = 1'b1;
      push("R10 standby entry holds");
      write(8'h12, 8'h3E, 16'h0000, "R10 write ignored in standby");
      write(8'h12, 8'h01, 16'h0000, "R10 other reg ignored in standby");
      idle(3, "R10 standby hold");
      @(negedge clk); standby = 1'b0;
      push("R10 standby exit");
      @(negedge clk);
      rst_n = 1'b0; wr_en = 1'b1; wr_sub = 8'h12; wr_addr = 8'h3E; wr_data = 16'h0009;
      @(negedge clk);
      wr_en = 1'b0; rst_n = 1'b1; m_pend = 1'b1;
      push("R11 write in reset ignored");
      write(8'h12, 8'h04, 16'h0000, "R11 pending set, default applied");
      @(negedge clk); por_n = 1'b0;
      m_route = 6'o55; m_pend = 1'b1;
      push("R1 power-on reset mutes");
      @(negedge clk); por_n = 1'b1;
      write(8'h12, 8'h3E, 16'h0000, "R7 route write after power-on");
      idle(2, "R3 drain");
      repeat (3) @(negedge clk);
      done = 1'b1;
   end

   initial begin
      for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog (all R): run hung, expected completion");
      end
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule